// File: doc/BRIEF.md
# Burst Test Pattern Generator and Checker

This block drives and checks fixed-content bursts for testing a link. Its transmit side sends one bit per clock. Each burst is a 16-bit test word repeated 128 times, giving 2048 bits with a valid strobe held high. A quiet interval of 512 bit times follows each burst, with the strobe low. Bursts keep coming while the enable input is high. Once a burst has started, it always finishes along with its quiet interval.

The receive side takes a bit stream and its valid strobe, for example a looped-back or recovered copy of the transmit side. The first valid cycle after a low cycle marks the start of a packet. From there the side steps through a local copy of the test word and compares bit by bit. It keeps saturating totals of compared bits and mismatches. At the end of a packet that held a mismatch it pulses a flag. The first two packets after reset can optionally be left out of all totals, so that a link can use them for phase calibration without inflating the error count.

Top module: `burst_pattern_tester`

## Requirements
- R1: While rst is high and in the cycle after it drops, tx_valid, tx_bit, pkt_err, bit_count and err_count are all zero.
- R2: A burst drives tx_valid high for exactly 2048 consecutive cycles. In burst cycle i, tx_bit equals bit (15 - i mod 16) of the word 16'b0000_1111_0110_0101, so the most significant bit goes first.
- R3: After every burst, tx_valid stays low for at least 512 cycles, and tx_bit is 0 whenever tx_valid is low. If gen_en is high at the end of those 512 cycles, the next burst begins in the very next cycle.
- R4: gen_en is only acted on between bursts. If gen_en goes high while idle, tx_valid rises in the following cycle. Dropping gen_en partway through a burst neither shortens that burst nor its quiet interval, after which the outputs stay idle.
- R5: Every cycle with rx_valid high compares rx_bit against the same test word, most significant bit first. The word position restarts at zero in the first rx_valid cycle after a low cycle, whatever position the previous packet ended at.
- R6: In a counted packet, bit_count rises by one for each rx_valid cycle and err_count rises by one for each mismatch. The new values are visible in the cycle after the bit is sampled.
- R7: A packet is a run of rx_valid high cycles. With skip_cal high, the first two packets after reset change neither counter and raise no pkt_err. With skip_cal low, every packet is counted.
- R8: pkt_err is high for exactly one cycle, the cycle after rx_valid is first sampled low following a packet. It is high only if that packet was counted and held at least one mismatch.
- R9: bit_count and err_count are CNT_W bits wide (default 32) and hold at 2^CNT_W - 1 instead of wrapping. err_count never exceeds bit_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Allows new bursts to start |
| tx_bit | output | 1 | Transmitted test bit |
| tx_valid | output | 1 | High during burst bits |
| rx_bit | input | 1 | Received bit to check |
| rx_valid | input | 1 | High while rx_bit carries packet data |
| skip_cal | input | 1 | Leave the first two packets out of the totals |
| bit_count | output | CNT_W | Saturating count of compared bits |
| err_count | output | CNT_W | Saturating count of mismatched bits |
| pkt_err | output | 1 | One-cycle pulse after a packet with errors |

## Verification
The bench first sends a short packet that ends partway through a word, then a clean packet. A checker that carried its word position across packets would report errors on the clean one. It also sends two calibration packets full of errors. A design that counted them, or flagged them, would show non-zero totals before any real packet. Both totals are pushed into saturation with a reduced counter width, and a wrapping counter would show a small value there. On the transmit side the bench checks every bit of two bursts and the exact quiet interval between them. It drops gen_en partway through the second burst to catch a generator that cuts a burst short or keeps going afterwards.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  // Test word, most significant bit is transmitted first.
  localparam logic [15:0] BPT_DEFAULT_WORD = 16'b0000_1111_0110_0101;

  typedef enum logic [1:0] {
    GEN_IDLE = 2'd0,
    GEN_DATA = 2'd1,
    GEN_GAP  = 2'd2
  } bpt_gen_state_e;

endpackage

// File: rtl/bpt_sat_counter.sv
module bpt_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/bpt_burst_gen.sv
module bpt_burst_gen
  import bpt_pkg::*;
#(
  parameter int              WORD_W   = 16,
  parameter logic [WORD_W-1:0] PATTERN = BPT_DEFAULT_WORD,
  parameter int              REPS     = 128,
  parameter int              GAP_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic gen_en,
  output logic tx_bit,
  output logic tx_valid
);
  localparam int PKT_BITS = WORD_W * REPS;
  localparam int IW       = (PKT_BITS > 2) ? $clog2(PKT_BITS) : 1;
  localparam int GW       = (GAP_BITS > 2) ? $clog2(GAP_BITS) : 1;
  localparam int PW       = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(PKT_BITS - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_BITS - 1);

  bpt_gen_state_e state_q, state_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [GW-1:0]  gap_q, gap_d;
  logic [PW-1:0]  pos_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    gap_d   = gap_q;
    unique case (state_q)
      GEN_IDLE: begin
        if (gen_en) begin
          state_d = GEN_DATA;
          idx_d   = '0;
        end
      end
      GEN_DATA: begin
        if (idx_q == IDX_LAST) begin
          state_d = GEN_GAP;
          gap_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      GEN_GAP: begin
        if (gap_q == GAP_LAST) begin
          if (gen_en) begin
            state_d = GEN_DATA;
            idx_d   = '0;
          end else begin
            state_d = GEN_IDLE;
          end
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      default: state_d = GEN_IDLE;
    endcase
  end

  assign pos_d = idx_d[PW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= GEN_IDLE;
      idx_q    <= '0;
      gap_q    <= '0;
      tx_valid <= 1'b0;
      tx_bit   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      gap_q    <= gap_d;
      tx_valid <= (state_d == GEN_DATA);
      tx_bit   <= (state_d == GEN_DATA) ? PATTERN[(WORD_W-1) - int'(pos_d)] : 1'b0;
    end
  end
endmodule

// File: rtl/bpt_burst_chk.sv
module bpt_burst_chk #(
  parameter int                WORD_W   = 16,
  parameter logic [WORD_W-1:0] PATTERN  = bpt_pkg::BPT_DEFAULT_WORD,
  parameter int                CAL_PKTS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic rx_valid,
  input  logic skip_cal,
  output logic bit_inc,
  output logic err_inc,
  output logic pkt_err
);
  localparam int PW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam int SW = $clog2(CAL_PKTS + 2);
  localparam logic [SW-1:0] CAL_N = SW'(CAL_PKTS);

  logic          vld_q;
  logic [PW-1:0] pos_q, pos_eff;
  logic          dirty_q;
  logic [SW-1:0] seen_q;
  logic          first, pkt_end, counted, expect_bit, mism;

  assign first      = rx_valid && !vld_q;
  assign pkt_end    = vld_q && !rx_valid;
  assign pos_eff    = first ? '0 : pos_q;
  assign expect_bit = PATTERN[(WORD_W-1) - int'(pos_eff)];
  assign counted    = !(skip_cal && (seen_q < CAL_N));
  assign mism       = rx_valid && (rx_bit != expect_bit);
  assign bit_inc    = rx_valid && counted;
  assign err_inc    = mism && counted;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      pos_q   <= '0;
      dirty_q <= 1'b0;
      seen_q  <= '0;
      pkt_err <= 1'b0;
    end else begin
      vld_q   <= rx_valid;
      pkt_err <= pkt_end && dirty_q;
      if (rx_valid) begin
        pos_q <= pos_eff + 1'b1;
      end
      if (first) begin
        dirty_q <= err_inc;
      end else if (rx_valid) begin
        dirty_q <= dirty_q || err_inc;
      end
      if (pkt_end && (seen_q < CAL_N)) begin
        seen_q <= seen_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_pattern_tester.sv
module burst_pattern_tester
  import bpt_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter logic [WORD_W-1:0] PATTERN  = BPT_DEFAULT_WORD,
  parameter int                REPS     = 128,
  parameter int                GAP_BITS = 512,
  parameter int                CAL_PKTS = 2,
  parameter int                CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_en,
  output logic             tx_bit,
  output logic             tx_valid,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             skip_cal,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count,
  output logic             pkt_err
);
  logic bit_inc, err_inc;

  bpt_burst_gen #(
    .WORD_W(WORD_W), .PATTERN(PATTERN), .REPS(REPS), .GAP_BITS(GAP_BITS)
  ) gen_i (
    .clk(clk), .rst(rst), .gen_en(gen_en), .tx_bit(tx_bit), .tx_valid(tx_valid)
  );

  bpt_burst_chk #(
    .WORD_W(WORD_W), .PATTERN(PATTERN), .CAL_PKTS(CAL_PKTS)
  ) chk_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_valid(rx_valid), .skip_cal(skip_cal),
    .bit_inc(bit_inc), .err_inc(err_inc), .pkt_err(pkt_err)
  );

  bpt_sat_counter #(.W(CNT_W)) bits_cnt_i (
    .clk(clk), .rst(rst), .inc(bit_inc), .count(bit_count)
  );

  bpt_sat_counter #(.W(CNT_W)) errs_cnt_i (
    .clk(clk), .rst(rst), .inc(err_inc), .count(err_count)
  );
endmodule

// File: rtl/burst_pattern_tester_chk.sv
module burst_pattern_tester_chk #(
  parameter int PKT_BITS = 2048,
  parameter int GAP_BITS = 512,
  parameter int CNT_W    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_bit,
  input logic             tx_valid,
  input logic             rx_valid,
  input logic [CNT_W-1:0] bit_count,
  input logic [CNT_W-1:0] err_count,
  input logic             pkt_err
);
  logic [31:0] hi_run_q, lo_run_q;
  logic        tx_prev_q, had_burst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run_q    <= '0;
      lo_run_q    <= '0;
      tx_prev_q   <= 1'b0;
      had_burst_q <= 1'b0;
    end else begin
      tx_prev_q <= tx_valid;
      hi_run_q  <= tx_valid ? hi_run_q + 1'b1 : '0;
      lo_run_q  <= tx_valid ? '0 : lo_run_q + 1'b1;
      if (tx_valid) had_burst_q <= 1'b1;
    end
  end

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_prev_q && !tx_valid) |-> (hi_run_q == 32'(PKT_BITS)));

  // R2
  burst_not_long_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_run_q >= 32'(PKT_BITS)) |-> !tx_valid);

  // R3
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_prev_q && tx_valid && had_burst_q) |-> (lo_run_q >= 32'(GAP_BITS)));

  // R3
  idle_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> !tx_bit);

  // R8
  pkt_err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_err |=> !pkt_err);

  // R8
  pkt_err_timing_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_err |-> (!$past(rx_valid) && $past(rx_valid, 2)));

  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)));

  // R9
  err_le_bits_chk: assert property (@(posedge clk) disable iff (rst)
    err_count <= bit_count);

  // R9
  bits_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bit_count >= $past(bit_count)));
endmodule

bind burst_pattern_tester burst_pattern_tester_chk #(
  .PKT_BITS(WORD_W * REPS), .GAP_BITS(GAP_BITS), .CNT_W(CNT_W)
) sva_i (
  .clk(clk), .rst(rst), .tx_bit(tx_bit), .tx_valid(tx_valid), .rx_valid(rx_valid),
  .bit_count(bit_count), .err_count(err_count), .pkt_err(pkt_err)
);

// File: tb/burst_pattern_tester_tb_top.sv
module burst_pattern_tester_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 12;
  localparam int MAXC       = (1 << CW) - 1;
  localparam logic [15:0] WORD = 16'b0000_1111_0110_0101;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          gen_en = 1'b0;
  logic          rx_bit = 1'b0;
  logic          rx_valid = 1'b0;
  logic          skip_cal = 1'b1;
  logic          tx_bit, tx_valid, pkt_err;
  logic [CW-1:0] bit_count, err_count;

  int checks = 0;
  int fails  = 0;
  int exp_bits = 0;
  int exp_errs = 0;
  int seen = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_pattern_tester #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .gen_en(gen_en), .tx_bit(tx_bit), .tx_valid(tx_valid),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .skip_cal(skip_cal),
    .bit_count(bit_count), .err_count(err_count), .pkt_err(pkt_err)
  );

  function automatic logic pat_bit(int i);
    return WORD[15 - (i % 16)];
  endfunction

  function automatic int sat(int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // mode 0: clean, 1: random flips, 2: every bit inverted
  task automatic send_pkt(int len, int mode, int gap);
    int nerr = 0;
    bit counted;
    for (int i = 0; i < len; i++) begin
      logic flip;
      @(negedge clk);
      flip = (mode == 2) || ((mode == 1) && ($urandom_range(0, 31) == 0));
      rx_valid = 1'b1;
      rx_bit   = pat_bit(i) ^ flip;
      nerr += int'(flip);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_bit   = 1'b0;
    counted = !(skip_cal && (seen < 2));
    if (seen < 2) seen++;
    if (counted) begin
      exp_bits = sat(exp_bits + len);
      exp_errs = sat(exp_errs + nerr);
    end
    @(negedge clk);
    chk("R8 flag at packet end", int'(pkt_err), int'(counted && (nerr > 0)));
    chk("R6/R7/R9 bit_count", int'(bit_count), exp_bits);
    chk("R6/R7/R9 err_count", int'(err_count), exp_errs);
    @(negedge clk);
    chk("R8 flag one cycle", int'(pkt_err), 0);
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    seen = 0; exp_bits = 0; exp_errs = 0;
    @(negedge clk);
    // R1
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 tx_bit", int'(tx_bit), 0);
    chk("R1 pkt_err", int'(pkt_err), 0);
    chk("R1 bit_count", int'(bit_count), 0);
    chk("R1 err_count", int'(err_count), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R7: two calibration packets full of errors, nothing counted
    skip_cal = 1'b1;
    send_pkt(2048, 1, 3);
    send_pkt(300, 2, 0);
    chk("R7 calibration excluded", int'(err_count), 0);

    // R5 R6: clean full packet, then a short one ending mid-word
    send_pkt(2048, 0, 5);
    send_pkt(37, 1, 0);
    // R5: restart at position zero gives no errors on a clean packet
    send_pkt(1000, 0, 2);
    send_pkt(500, 1, 7);
    for (int k = 0; k < 4; k++) send_pkt($urandom_range(1, 600), 1, $urandom_range(0, 9));

    // R9: saturation of both totals
    send_pkt(2048, 2, 0);
    send_pkt(2048, 2, 0);
    chk("R9 bit_count saturated", int'(bit_count), MAXC);
    chk("R9 err_count saturated", int'(err_count), MAXC);

    // R7: skip disabled, first packet after reset counted
    do_reset();
    skip_cal = 1'b0;
    send_pkt(64, 2, 0);
    chk("R7 counted without skip", int'(err_count), 64);
    send_pkt(1, 0, 0);

    // Generator
    chk("R4 idle while disabled", int'(tx_valid), 0);
    @(negedge clk);
    gen_en = 1'b1;
    for (int b = 0; b < 2; b++) begin
      int bad = 0;
      int gap_hi = 0;
      for (int i = 0; i < 2048; i++) begin
        @(negedge clk);
        if (!tx_valid || (tx_bit != pat_bit(i))) bad++;
        if (b == 1 && i == 100) gen_en = 1'b0;
      end
      chk("R2 burst content", bad, 0);
      for (int i = 0; i < 512; i++) begin
        @(negedge clk);
        if (tx_valid || tx_bit) gap_hi++;
      end
      chk("R3 quiet interval", gap_hi, 0);
    end
    begin
      int hi = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (tx_valid) hi++;
      end
      chk("R4 stops after enable drop", hi, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule